// File: doc/BRIEF.md
# Late Word-Level Squash Resolver

This block holds the unresolved potential read-after-write conflicts that a line-granular speculation directory defers instead of squashing at once. When a speculative consumer thread reads a line that is handled either by deferred word checking or by value prediction, the directory allocates an entry here. The entry records the line, the consumer thread, the policy in force and the line value handed to the consumer. From then on every commit of an older thread to that line marks, word by word, which words a predecessor actually changed.

Memory traffic never carries word addresses. The word detail enters only at the end. Once the consumer becomes the oldest, non-speculative thread, it presents the per-word load bits it kept locally. The block then walks its entries at a fixed cost per entry, intersects the load bits with the accumulated change masks of all entries owned by that consumer, and answers with a single squash or no-squash verdict. The entries it used are released in the same cycle. A full buffer refuses new entries, and the directory then falls back to plain line-level speculation for that read.

Top module: `spec_pend_buf`

## Requirements
- R1: After synchronous reset no entry is held, `rsp_valid` and `rsv_busy` are 0, and an allocation request is accepted in the same cycle.
- R2: `alloc_accept` is 1 exactly when `alloc_valid` is 1 and fewer than ENTRIES entries are held; a refused request stores nothing.
- R3: For an entry under the deferred policy (`alloc_policy`=0), each qualifying commit ORs its `cmt_wmask` into the entry's change mask, where bit w stands for word w of the line; commits accumulate.
- R4: For an entry under the value-predicted policy (`alloc_policy`=1), a qualifying commit sets bit w only when `cmt_wmask[w]` is 1 and committed word w (bits 32w+31..32w of `cmt_data`) differs from predicted word w (same bits of `alloc_pred`).
- R5: A commit qualifies for an entry only when the lines are equal and the committing thread is strictly older: (entry thread − commit thread) modulo 2^TID_W lies in 1 .. 2^(TID_W−1)−1.
- R6: The verdict `rsp_squash` is 1 exactly when, over all held entries whose thread equals the request thread, the OR of (load bits AND change mask) is nonzero; with no such entry the verdict is no-squash.
- R7: A request is taken only when `rsv_busy` is 0; `rsv_busy` stays 1 during the walk, and `rsp_valid` is a one-cycle pulse ENTRIES×SCAN_CYC cycles after the accepting edge. Requests during the walk are ignored.
- R8: The entries that matched a request are released at the edge that raises `rsp_valid`, so their slots are free and a later request for that thread finds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_tid | input | TID_W | Consumer thread sequence number |
| alloc_line | input | LINE_W | Line tag |
| alloc_policy | input | 1 | 0 = deferred word check, 1 = value-predicted |
| alloc_pred | input | WORDS×DATA_W | Line value handed to the consumer |
| alloc_accept | output | 1 | Request stored this cycle |
| cmt_valid | input | 1 | Predecessor commit |
| cmt_tid | input | TID_W | Committing thread |
| cmt_line | input | LINE_W | Committed line |
| cmt_wmask | input | WORDS | Words written by the committing thread |
| cmt_data | input | WORDS×DATA_W | Committed line data |
| rsv_valid | input | 1 | Resolve request from a now non-speculative consumer |
| rsv_tid | input | TID_W | Consumer thread to resolve |
| rsv_load | input | WORDS | Consumer's per-word load bits |
| rsv_busy | output | 1 | Walk in progress, requests ignored |
| rsp_valid | output | 1 | Verdict pulse |
| rsp_squash | output | 1 | Verdict: 1 = squash |

## Verification
The bench sweeps every change mask against every load pattern for the deferred policy, and every pattern of differing words against every load pattern for the value-predicted one; a resolver that compared lines instead of words, or flagged equal predicted data, would squash where no word overlaps. Thread ages are probed across the sequence-number wrap and at the half-range boundary, where a plain unsigned compare would let younger threads or a thread's own commits poison the mask. The full buffer, the release at response time and two entries of one consumer on different lines are exercised, catching a design that leaks slots, frees too early or reports only the first matching entry. A request sent in the middle of a walk must neither produce a second response nor free the entry it names.

// File: rtl/spb_pkg.sv
package spb_pkg;
    parameter int WORDS  = 4;
    parameter int DATA_W = 32;
    parameter int TID_W  = 8;
    parameter int LINE_W = 26;
    localparam int LINE_BITS = WORDS * DATA_W;

    typedef enum logic {
        POL_DEFER = 1'b0,
        POL_VPRED = 1'b1
    } policy_e;

    typedef struct packed {
        logic                 vld;
        logic [LINE_W-1:0]    tag;
        logic [TID_W-1:0]     tid;
        policy_e              pol;
        logic [WORDS-1:0]     mask;
        logic [LINE_BITS-1:0] pred;
    } entry_t;

    // a is strictly older than b in a wrapping sequence space
    function automatic logic older_than(input logic [TID_W-1:0] a,
                                        input logic [TID_W-1:0] b);
        logic [TID_W-1:0] d;
        d = b - a;
        return (d != '0) && !d[TID_W-1];
    endfunction
endpackage

// File: rtl/spb_entry.sv
module spb_entry
    import spb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_we,
    input  logic [LINE_W-1:0]    a_line,
    input  logic [TID_W-1:0]     a_tid,
    input  policy_e              a_pol,
    input  logic [LINE_BITS-1:0] a_pred,
    input  logic                 clr,
    input  logic                 c_valid,
    input  logic [LINE_W-1:0]    c_line,
    input  logic [TID_W-1:0]     c_tid,
    input  logic [WORDS-1:0]     c_wmask,
    input  logic [LINE_BITS-1:0] c_data,
    output logic                 vld,
    output logic [TID_W-1:0]     tid,
    output logic [WORDS-1:0]     mask
);
    entry_t q;
    logic   qual;
    logic [WORDS-1:0] set_bits;

    always_comb begin
        qual = q.vld && c_valid && (c_line == q.tag) && older_than(c_tid, q.tid);
        for (int w = 0; w < WORDS; w++) begin
            if (q.pol == POL_DEFER)
                set_bits[w] = c_wmask[w];
            else
                set_bits[w] = c_wmask[w] &&
                    (c_data[w*DATA_W +: DATA_W] != q.pred[w*DATA_W +: DATA_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (alloc_we) begin
            q.vld  <= 1'b1;
            q.tag  <= a_line;
            q.tid  <= a_tid;
            q.pol  <= a_pol;
            q.mask <= '0;
            q.pred <= a_pred;
        end else if (clr) begin
            q.vld <= 1'b0;
        end else if (qual) begin
            q.mask <= q.mask | set_bits;
        end
    end

    assign vld  = q.vld;
    assign tid  = q.tid;
    assign mask = q.mask;
endmodule

// File: rtl/spb_pick.sv
module spb_pick #(
    parameter int N = 128
) (
    input  logic [N-1:0]         vld,
    output logic                 has_free,
    output logic [$clog2(N)-1:0] free_idx
);
    localparam int IW = $clog2(N);

    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                has_free = 1'b1;
                free_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/spb_scan.sv
module spb_scan
    import spb_pkg::*;
#(
    parameter int N = 128,
    parameter int S = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rsv_valid,
    input  logic [TID_W-1:0]     rsv_tid,
    input  logic [WORDS-1:0]     rsv_load,
    input  logic [N-1:0]         ent_vld,
    input  logic [TID_W-1:0]     ent_tid  [N],
    input  logic [WORDS-1:0]     ent_mask [N],
    output logic                 rsv_busy,
    output logic                 rsp_valid,
    output logic                 rsp_squash,
    output logic [N-1:0]         clr_vec
);
    localparam int IW = $clog2(N);
    localparam int SW = (S > 1) ? $clog2(S) : 1;

    logic              busy_q, acc_q;
    logic [IW-1:0]     ptr_q;
    logic [SW-1:0]     sub_q;
    logic [TID_W-1:0]  tid_q;
    logic [WORDS-1:0]  load_q;
    logic [N-1:0]      hit_q;
    logic              cur_hit, cur_sq, step, last;

    always_comb begin
        cur_hit = ent_vld[ptr_q] && (ent_tid[ptr_q] == tid_q);
        cur_sq  = cur_hit && |(load_q & ent_mask[ptr_q]);
        step    = busy_q && (sub_q == SW'(S - 1));
        last    = step && (ptr_q == IW'(N - 1));
        clr_vec = '0;
        if (last) begin
            clr_vec = hit_q;
            if (cur_hit) clr_vec[ptr_q] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            acc_q      <= 1'b0;
            ptr_q      <= '0;
            sub_q      <= '0;
            tid_q      <= '0;
            load_q     <= '0;
            hit_q      <= '0;
            rsp_valid  <= 1'b0;
            rsp_squash <= 1'b0;
        end else begin
            rsp_valid  <= 1'b0;
            rsp_squash <= 1'b0;
            if (!busy_q) begin
                if (rsv_valid) begin
                    busy_q <= 1'b1;
                    acc_q  <= 1'b0;
                    ptr_q  <= '0;
                    sub_q  <= '0;
                    hit_q  <= '0;
                    tid_q  <= rsv_tid;
                    load_q <= rsv_load;
                end
            end else if (step) begin
                sub_q <= '0;
                acc_q <= acc_q | cur_sq;
                if (cur_hit) hit_q[ptr_q] <= 1'b1;
                ptr_q <= ptr_q + IW'(1);
                if (last) begin
                    busy_q     <= 1'b0;
                    rsp_valid  <= 1'b1;
                    rsp_squash <= acc_q | cur_sq;
                end
            end else begin
                sub_q <= sub_q + SW'(1);
            end
        end
    end

    assign rsv_busy = busy_q;
endmodule

// File: rtl/spec_pend_buf.sv
module spec_pend_buf
    import spb_pkg::*;
#(
    parameter int ENTRIES  = 128,
    parameter int SCAN_CYC = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         alloc_valid,
    input  logic [spb_pkg::TID_W-1:0]    alloc_tid,
    input  logic [spb_pkg::LINE_W-1:0]   alloc_line,
    input  logic                         alloc_policy,
    input  logic [spb_pkg::LINE_BITS-1:0] alloc_pred,
    output logic                         alloc_accept,
    input  logic                         cmt_valid,
    input  logic [spb_pkg::TID_W-1:0]    cmt_tid,
    input  logic [spb_pkg::LINE_W-1:0]   cmt_line,
    input  logic [spb_pkg::WORDS-1:0]    cmt_wmask,
    input  logic [spb_pkg::LINE_BITS-1:0] cmt_data,
    input  logic                         rsv_valid,
    input  logic [spb_pkg::TID_W-1:0]    rsv_tid,
    input  logic [spb_pkg::WORDS-1:0]    rsv_load,
    output logic                         rsv_busy,
    output logic                         rsp_valid,
    output logic                         rsp_squash
);
    localparam int IW = $clog2(ENTRIES);

    logic [ENTRIES-1:0] vld_vec;
    logic [ENTRIES-1:0] clr_vec;
    logic [TID_W-1:0]   ent_tid  [ENTRIES];
    logic [WORDS-1:0]   ent_mask [ENTRIES];
    logic               has_free;
    logic [IW-1:0]      free_idx;

    spb_pick #(.N(ENTRIES)) u_pick (
        .vld      (vld_vec),
        .has_free (has_free),
        .free_idx (free_idx)
    );

    assign alloc_accept = alloc_valid && has_free;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        spb_entry u_ent (
            .clk      (clk),
            .rst      (rst),
            .alloc_we (alloc_accept && (free_idx == IW'(i))),
            .a_line   (alloc_line),
            .a_tid    (alloc_tid),
            .a_pol    (policy_e'(alloc_policy)),
            .a_pred   (alloc_pred),
            .clr      (clr_vec[i]),
            .c_valid  (cmt_valid),
            .c_line   (cmt_line),
            .c_tid    (cmt_tid),
            .c_wmask  (cmt_wmask),
            .c_data   (cmt_data),
            .vld      (vld_vec[i]),
            .tid      (ent_tid[i]),
            .mask     (ent_mask[i])
        );
    end

    spb_scan #(.N(ENTRIES), .S(SCAN_CYC)) u_scan (
        .clk        (clk),
        .rst        (rst),
        .rsv_valid  (rsv_valid),
        .rsv_tid    (rsv_tid),
        .rsv_load   (rsv_load),
        .ent_vld    (vld_vec),
        .ent_tid    (ent_tid),
        .ent_mask   (ent_mask),
        .rsv_busy   (rsv_busy),
        .rsp_valid  (rsp_valid),
        .rsp_squash (rsp_squash),
        .clr_vec    (clr_vec)
    );
endmodule

// File: rtl/spb_chk.sv
module spb_chk #(
    parameter int N = 128,
    parameter int S = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         alloc_valid,
    input logic         alloc_accept,
    input logic         rsv_busy,
    input logic         rsp_valid,
    input logic         rsp_squash,
    input logic [N-1:0] vld
);
    localparam int WIN = N * S;
    localparam int CW  = $clog2(WIN + 2) + 1;

    logic [CW-1:0] walk_cnt;
    logic          rst_d = 1'b0;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst || !rsv_busy) walk_cnt <= '0;
        else                  walk_cnt <= walk_cnt + CW'(1);
        if (rst_d && !rst) begin
            a_reset_idle_r1: assert (!rsv_busy && !rsp_valid && vld == '0);
        end
    end

    p_refuse_full_r2: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !alloc_accept) |-> ($countones(vld) == N));

    p_verdict_qual_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_squash |-> rsp_valid);

    p_rsp_single_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_rsp_idle_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !rsv_busy);

    p_rsp_latency_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (walk_cnt == CW'(WIN)));

    p_rsp_follows_busy_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(rsv_busy));
endmodule

bind spec_pend_buf spb_chk #(.N(ENTRIES), .S(SCAN_CYC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .alloc_valid  (alloc_valid),
    .alloc_accept (alloc_accept),
    .rsv_busy     (rsv_busy),
    .rsp_valid    (rsp_valid),
    .rsp_squash   (rsp_squash),
    .vld          (vld_vec)
);

// File: tb/sim_spec_pend_buf.sv
module sim_spec_pend_buf;
    import spb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int S = 3;
    localparam int LAT = N * S + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic                 alloc_valid = 0, alloc_policy = 0, alloc_accept;
    logic [TID_W-1:0]     alloc_tid = 0, cmt_tid = 0, rsv_tid = 0;
    logic [LINE_W-1:0]    alloc_line = 0, cmt_line = 0;
    logic [LINE_BITS-1:0] alloc_pred = 0, cmt_data = 0, pred_line;
    logic                 cmt_valid = 0, rsv_valid = 0;
    logic [WORDS-1:0]     cmt_wmask = 0, rsv_load = 0;
    logic                 rsv_busy, rsp_valid, rsp_squash;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_pend_buf #(.ENTRIES(N), .SCAN_CYC(S)) u0 (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_line(alloc_line),
        .alloc_policy(alloc_policy), .alloc_pred(alloc_pred), .alloc_accept(alloc_accept),
        .cmt_valid(cmt_valid), .cmt_tid(cmt_tid), .cmt_line(cmt_line),
        .cmt_wmask(cmt_wmask), .cmt_data(cmt_data),
        .rsv_valid(rsv_valid), .rsv_tid(rsv_tid), .rsv_load(rsv_load),
        .rsv_busy(rsv_busy), .rsp_valid(rsp_valid), .rsp_squash(rsp_squash)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_alloc(input logic [TID_W-1:0] t, input logic [LINE_W-1:0] l,
                            input logic p, output logic acc);
        alloc_valid = 1; alloc_tid = t; alloc_line = l; alloc_policy = p; alloc_pred = pred_line;
        #1 acc = alloc_accept;
        @(posedge clk); @(negedge clk);
        alloc_valid = 0;
    endtask

    task automatic do_commit(input logic [TID_W-1:0] t, input logic [LINE_W-1:0] l,
                             input logic [WORDS-1:0] m, input logic [LINE_BITS-1:0] d);
        cmt_valid = 1; cmt_tid = t; cmt_line = l; cmt_wmask = m; cmt_data = d;
        @(posedge clk); @(negedge clk);
        cmt_valid = 0;
    endtask

    task automatic do_resolve(input logic [TID_W-1:0] t, input logic [WORDS-1:0] ld,
                              output logic sq);
        int lat;
        rsv_valid = 1; rsv_tid = t; rsv_load = ld;
        @(posedge clk); @(negedge clk);
        rsv_valid = 0;
        lat = 1;
        while (!rsp_valid && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        chk("R7 latency", lat, LAT);
        sq = rsp_squash;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic acc, sq;
        logic [LINE_BITS-1:0] cd;
        for (int w = 0; w < WORDS; w++) pred_line[w*DATA_W +: DATA_W] = DATA_W'(16 * (w + 1));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 rsv_busy", rsv_busy, 0);
        alloc_valid = 1;
        #1 chk("R1 accept", alloc_accept, 1);
        alloc_valid = 0;
        do_resolve(8'd7, 4'hF, sq);
        chk("R1 empty verdict", sq, 0);

        // R3 sweep: deferred policy, every commit mask x every load pattern
        for (int m = 0; m < 16; m++) begin
            for (int l = 0; l < 16; l++) begin
                do_alloc(8'd20, 26'd5, 1'b0, acc);
                do_commit(8'd19, 26'd5, WORDS'(m), '0);
                do_resolve(8'd20, WORDS'(l), sq);
                chk("R3 defer sweep", sq, ((m & l) != 0));
            end
        end
        // R3 accumulation: word 3 then word 1
        do_alloc(8'd20, 26'd5, 1'b0, acc);
        do_commit(8'd18, 26'd5, 4'b1000, '0);
        do_commit(8'd19, 26'd5, 4'b0010, '0);
        do_resolve(8'd20, 4'b0010, sq);
        chk("R3 accumulate squash", sq, 1);
        do_alloc(8'd20, 26'd5, 1'b0, acc);
        do_commit(8'd19, 26'd5, 4'b1000, '0);
        do_resolve(8'd20, 4'b0010, sq);
        chk("R3 disjoint no squash", sq, 0);

        // R4 sweep: value-predicted, differing-word pattern x load pattern
        for (int d = 0; d < 16; d++) begin
            for (int l = 0; l < 16; l++) begin
                for (int w = 0; w < WORDS; w++)
                    cd[w*DATA_W +: DATA_W] = pred_line[w*DATA_W +: DATA_W] + DATA_W'((d >> w) & 1);
                do_alloc(8'd40, 26'd9, 1'b1, acc);
                do_commit(8'd39, 26'd9, 4'b1111, cd);
                do_resolve(8'd40, WORDS'(l), sq);
                chk("R4 predict sweep", sq, ((d & l) != 0));
            end
        end
        // R4 unwritten word with different data must not count
        do_alloc(8'd40, 26'd9, 1'b1, acc);
        do_commit(8'd39, 26'd9, 4'b0001, ~pred_line);
        do_resolve(8'd40, 4'b0010, sq);
        chk("R4 unwritten word", sq, 0);

        // R5 thread age and line qualification (entry thread 2, line 3)
        begin
            logic [TID_W-1:0] ct [6] = '{8'd254, 8'd131, 8'd5, 8'd2, 8'd129, 8'd1};
            logic [LINE_W-1:0] cl [6] = '{26'd3, 26'd3, 26'd3, 26'd3, 26'd3, 26'd4};
            logic exp_sq [6] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
            for (int k = 0; k < 6; k++) begin
                do_alloc(8'd2, 26'd3, 1'b0, acc);
                do_commit(ct[k], cl[k], 4'b0001, '0);
                do_resolve(8'd2, 4'b1111, sq);
                chk("R5 age/line", sq, exp_sq[k]);
            end
        end

        // R2 full buffer, R8 release
        for (int k = 0; k < N; k++) begin
            do_alloc(TID_W'(50 + k), 26'd11, 1'b0, acc);
            chk("R2 accept while free", acc, 1);
        end
        do_alloc(8'd54, 26'd11, 1'b0, acc);
        chk("R2 refuse when full", acc, 0);
        do_commit(8'd49, 26'd11, 4'b0001, '0);
        do_resolve(8'd54, 4'b0001, sq);
        chk("R6 refused entry absent", sq, 0);
        do_resolve(8'd50, 4'b0001, sq);
        chk("R6 match squash", sq, 1);
        do_alloc(8'd55, 26'd12, 1'b0, acc);
        chk("R8 slot freed", acc, 1);
        do_resolve(8'd50, 4'b0001, sq);
        chk("R8 resolved entry gone", sq, 0);
        do_resolve(8'd51, 4'b0000, sq);
        do_resolve(8'd52, 4'b0000, sq);
        do_resolve(8'd53, 4'b0000, sq);
        do_resolve(8'd55, 4'b0000, sq);

        // R6 two entries of one consumer OR together
        do_alloc(8'd70, 26'd1, 1'b0, acc);
        do_alloc(8'd70, 26'd2, 1'b0, acc);
        do_commit(8'd69, 26'd1, 4'b0001, '0);
        do_commit(8'd69, 26'd2, 4'b0100, '0);
        do_resolve(8'd70, 4'b0100, sq);
        chk("R6 OR of entries", sq, 1);
        do_resolve(8'd70, 4'b1111, sq);
        chk("R8 both entries freed", sq, 0);

        // R7 request during a walk is ignored
        do_alloc(8'd80, 26'd7, 1'b0, acc);
        do_commit(8'd79, 26'd7, 4'b0001, '0);
        rsv_valid = 1; rsv_tid = 8'd90; rsv_load = 4'hF;
        @(posedge clk); @(negedge clk);
        rsv_valid = 0;
        @(negedge clk);
        chk("R7 busy in walk", rsv_busy, 1);
        rsv_valid = 1; rsv_tid = 8'd80; rsv_load = 4'b0001;
        @(posedge clk); @(negedge clk);
        rsv_valid = 0;
        while (!rsp_valid) @(negedge clk);
        chk("R7 first verdict", rsp_squash, 0);
        begin
            int extra = 0;
            for (int k = 0; k < LAT + 2; k++) begin
                @(negedge clk);
                if (rsp_valid) extra++;
            end
            chk("R7 no second response", extra, 0);
        end
        do_resolve(8'd80, 4'b0001, sq);
        chk("R7 ignored request kept entry", sq, 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule